// File: doc/BRIEF.md
# Power-On Strap Sampling Sequencer

This block handles five bidirectional board pins that carry configuration straps at power-up and clock outputs afterwards. When the supply-good indication rises, the block keeps every pad driver for those pins in high impedance while a fixed window runs. This lets the external strap resistors set each pin level. At the end of the window the block captures the synchronized pin levels once. One cycle later it turns the pad drivers on and raises `config_valid`.

The captured bits hold:
- a three-bit frequency-select code, decoded into a one-hot table index and into CPU and PCI target frequencies in kHz;
- a CPU output swing-select bit;
- a pin-role bit.

The role bit chooses how two further shared pins behave. They can be active-low power-down and CPU-stop request inputs, or they can be driven clock outputs. Only a loss of supply-good clears the captured configuration.

Top module: `strap_seq_top`

## Requirements
- R1: While `supply_good` is low, all pad enables, `config_valid`, `pwr_down_req`, `cpu_stop_req` and all captured fields read 0 (`cpu_khz`/`pci_khz` then show the code-0 entry).
- R2: After `supply_good` rises, `strap_pad_oe` and `shared_pad_oe` stay 0 and `config_valid` stays 0 for `WINDOW_CYCLES` rising clock edges. A drop of `supply_good` inside the window restarts it in full.
- R3: The pins pass through a two-flop synchronizer and are captured on rising edge `WINDOW_CYCLES`. On edge `WINDOW_CYCLES+1`, `strap_pad_oe` becomes 5'b11111 and `config_valid` becomes 1 in the same cycle.
- R4: The capture maps `strap_pin_in[2:0]` to `freq_code`, `strap_pin_in[3]` to `cpu_swing_25v` (0 = 3.3 V buffers, 1 = 2.5 V) and `strap_pin_in[4]` to `mode_sel`.
- R5: `cpu_khz`/`pci_khz` follow the code: 0: 50000/25000, 1: 75000/32000, 2: 83300/41650, 3: 68500/34250, 4: 55000/27500, 5: 75000/37500, 6: 60000/30000, 7: 66800/33400.
- R6: `freq_onehot` has exactly bit `freq_code` set.
- R7: Once captured, the configuration ignores any change on `strap_pin_in`. Only `supply_good` going low clears it.
- R8: With `mode_sel`=1 and `config_valid`=1, `shared_pad_oe` is 2'b11 and both request outputs are 0 whatever `shared_pin_in` holds.
- R9: With `mode_sel`=0, `shared_pad_oe` stays 2'b00. After `config_valid`, `pwr_down_req` is the inverse of `shared_pin_in[0]` and `cpu_stop_req` the inverse of `shared_pin_in[1]`, each two rising edges after the pin changes. Both are 0 before `config_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| supply_good | input | 1 | Supply-good, active high; low clears everything asynchronously |
| strap_pin_in | input | 5 | Pad input levels of the five dual-purpose pins |
| shared_pin_in | input | 2 | Pad input levels of the two role-selected pins (0: power-down, 1: CPU stop) |
| strap_pad_oe | output | 5 | Output enables of the dual-purpose pads |
| shared_pad_oe | output | 2 | Output enables of the role-selected pads |
| config_valid | output | 1 | Captured configuration is valid and drivers are on |
| freq_code | output | 3 | Captured frequency-select code |
| freq_onehot | output | 8 | One-hot table index of the code |
| cpu_khz | output | 17 | CPU/SDRAM target frequency in kHz |
| pci_khz | output | 17 | PCI target frequency in kHz |
| cpu_swing_25v | output | 1 | Captured swing select, 1 = 2.5 V |
| mode_sel | output | 1 | Captured pin-role bit |
| pwr_down_req | output | 1 | Power-down request (role 0 only) |
| cpu_stop_req | output | 1 | CPU-stop request (role 0 only) |

## Verification
The capture path is run through all eight frequency codes. The swing and role bits are varied across those runs, so a swapped field, a wrong table entry or a bad one-hot decode lands on a distinct failing code. Each run holds the drivers off and checks them at every edge of the window, which separates an early or late enable from a correct one. After capture, the strap inputs are inverted to show the latches no longer follow them. The shared pins are driven low under both role values, which tells a working request path apart from one that ignores the role bit. A supply drop in the middle of the window shows whether the timer restarts or continues.

// File: rtl/strap_pkg.sv
package strap_pkg;
    localparam int NUM_STRAPS = 5;
    localparam int CODE_W     = 3;
    localparam int NUM_CODES  = 1 << CODE_W;
    localparam int KHZ_W      = 17;

    typedef struct packed {
        logic              role;   // pin bit 4
        logic              swing;  // pin bit 3
        logic [CODE_W-1:0] code;   // pin bits 2:0
    } strap_t;

    function automatic logic [KHZ_W-1:0] cpu_khz_of(input logic [CODE_W-1:0] c);
        case (c)
            3'd0:    return KHZ_W'(50000);
            3'd1:    return KHZ_W'(75000);
            3'd2:    return KHZ_W'(83300);
            3'd3:    return KHZ_W'(68500);
            3'd4:    return KHZ_W'(55000);
            3'd5:    return KHZ_W'(75000);
            3'd6:    return KHZ_W'(60000);
            default: return KHZ_W'(66800);
        endcase
    endfunction

    function automatic logic [KHZ_W-1:0] pci_khz_of(input logic [CODE_W-1:0] c);
        case (c)
            3'd0:    return KHZ_W'(25000);
            3'd1:    return KHZ_W'(32000);
            3'd2:    return KHZ_W'(41650);
            3'd3:    return KHZ_W'(34250);
            3'd4:    return KHZ_W'(27500);
            3'd5:    return KHZ_W'(37500);
            3'd6:    return KHZ_W'(30000);
            default: return KHZ_W'(33400);
        endcase
    endfunction
endpackage

// File: rtl/strap_sync.sv
module strap_sync #(
    parameter int WIDTH = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    typedef struct packed {
        logic [WIDTH-1:0] s1;
        logic [WIDTH-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = d;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q = st_q.s2;

    // R3: output follows the input two edges later
    assert_two_stage_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(st_q.s1) == st_q.s2 || !$past(rst_n));
endmodule

// File: rtl/strap_window_timer.sv
module strap_window_timer #(
    parameter int WINDOW_CYCLES = 28636
) (
    input  logic clk,
    input  logic rst_n,
    output logic sample_now,
    output logic sampled,
    output logic drive_en
);
    localparam int CW = $clog2(WINDOW_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(WINDOW_CYCLES - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          sampled;
        logic          drive;
    } tmr_t;

    tmr_t st_d, st_q;
    logic expire;

    always_comb begin
        st_d   = st_q;
        expire = !st_q.sampled && (st_q.cnt == LAST);
        if (!st_q.sampled) begin
            if (expire) st_d.sampled = 1'b1;
            else        st_d.cnt     = st_q.cnt + 1'b1;
        end
        st_d.drive = st_q.sampled;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sample_now = expire;
    assign sampled    = st_q.sampled;
    assign drive_en   = st_q.drive;

    // R2: the counter never passes the last window cycle
    assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= LAST);
    // R3: drivers come on only one edge after the capture
    assert_drive_after_sample_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.drive) |-> $past(st_q.sampled));
    // R7: the window fires once per power-up
    assert_one_shot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.sampled |=> st_q.sampled && !expire);
endmodule

// File: rtl/strap_capture.sv
module strap_capture
    import strap_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sample_now,
    input  strap_t               pins,
    output strap_t               cfg,
    output logic [NUM_CODES-1:0] onehot,
    output logic [KHZ_W-1:0]     cpu_khz,
    output logic [KHZ_W-1:0]     pci_khz
);
    typedef struct packed {
        strap_t lat;
    } cap_t;

    cap_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sample_now) st_d.lat = pins;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        onehot = '0;
        for (int i = 0; i < NUM_CODES; i++)
            onehot[i] = (st_q.lat.code == CODE_W'(i));
        cpu_khz = cpu_khz_of(st_q.lat.code);
        pci_khz = pci_khz_of(st_q.lat.code);
    end

    assign cfg = st_q.lat;

    // R3/R4: the capture takes the synchronized pins of that edge
    assert_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sample_now |=> st_q.lat == $past(pins));
    // R7: without a capture pulse the latches hold
    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_now |=> $stable(st_q.lat));
    // R6: index is one-hot
    assert_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(onehot) == 1);
endmodule

// File: rtl/strap_seq_top.sv
module strap_seq_top
    import strap_pkg::*;
#(
    parameter int WINDOW_CYCLES = 28636
) (
    input  logic                 clk,
    input  logic                 supply_good,
    input  logic [4:0]           strap_pin_in,
    input  logic [1:0]           shared_pin_in,
    output logic [4:0]           strap_pad_oe,
    output logic [1:0]           shared_pad_oe,
    output logic                 config_valid,
    output logic [2:0]           freq_code,
    output logic [7:0]           freq_onehot,
    output logic [16:0]          cpu_khz,
    output logic [16:0]          pci_khz,
    output logic                 cpu_swing_25v,
    output logic                 mode_sel,
    output logic                 pwr_down_req,
    output logic                 cpu_stop_req
);
    logic [NUM_STRAPS-1:0] strap_sync_q;
    logic [1:0]            shared_sync_q;
    logic                  sample_now, sampled, drive_en;
    strap_t                cfg;

    strap_sync #(.WIDTH(NUM_STRAPS)) u_strap_sync (
        .clk(clk), .rst_n(supply_good), .d(strap_pin_in), .q(strap_sync_q));

    strap_sync #(.WIDTH(2)) u_shared_sync (
        .clk(clk), .rst_n(supply_good), .d(shared_pin_in), .q(shared_sync_q));

    strap_window_timer #(.WINDOW_CYCLES(WINDOW_CYCLES)) u_timer (
        .clk(clk), .rst_n(supply_good), .sample_now(sample_now),
        .sampled(sampled), .drive_en(drive_en));

    strap_capture u_capture (
        .clk(clk), .rst_n(supply_good), .sample_now(sample_now),
        .pins(strap_t'(strap_sync_q)), .cfg(cfg), .onehot(freq_onehot),
        .cpu_khz(cpu_khz), .pci_khz(pci_khz));

    always_comb begin
        strap_pad_oe  = {NUM_STRAPS{drive_en}};
        shared_pad_oe = {2{drive_en & cfg.role}};
        pwr_down_req  = drive_en & ~cfg.role & ~shared_sync_q[0];
        cpu_stop_req  = drive_en & ~cfg.role & ~shared_sync_q[1];
    end

    assign config_valid  = drive_en;
    assign freq_code     = cfg.code;
    assign cpu_swing_25v = cfg.swing;
    assign mode_sel      = cfg.role;

    // R2: no pad is driven before the configuration is valid
    assert_no_drive_early_R2: assert property (@(posedge clk) disable iff (!supply_good)
        !config_valid |-> (strap_pad_oe == '0) && (shared_pad_oe == '0));
    // R8: role 1 silences both requests
    assert_role1_quiet_R8: assert property (@(posedge clk) disable iff (!supply_good)
        mode_sel |-> !pwr_down_req && !cpu_stop_req);
    // R9: role 0 never drives the shared pads
    assert_role0_hiz_R9: assert property (@(posedge clk) disable iff (!supply_good)
        !mode_sel |-> shared_pad_oe == 2'b00);
    // R7: configuration holds while valid
    assert_cfg_stable_R7: assert property (@(posedge clk) disable iff (!supply_good)
        config_valid |=> $stable(freq_code) && $stable(mode_sel) && $stable(cpu_swing_25v));
endmodule

// File: tb/tb_strap_seq_top.sv
module tb_strap_seq_top;
    localparam int WIN = 40;

    logic        clk = 1'b0;
    logic        supply_good = 1'b0;
    logic [4:0]  strap_pin_in = '0;
    logic [1:0]  shared_pin_in = 2'b11;
    logic [4:0]  strap_pad_oe;
    logic [1:0]  shared_pad_oe;
    logic        config_valid;
    logic [2:0]  freq_code;
    logic [7:0]  freq_onehot;
    logic [16:0] cpu_khz, pci_khz;
    logic        cpu_swing_25v, mode_sel, pwr_down_req, cpu_stop_req;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    strap_seq_top #(.WINDOW_CYCLES(WIN)) dut (
        .clk(clk), .supply_good(supply_good), .strap_pin_in(strap_pin_in),
        .shared_pin_in(shared_pin_in), .strap_pad_oe(strap_pad_oe),
        .shared_pad_oe(shared_pad_oe), .config_valid(config_valid),
        .freq_code(freq_code), .freq_onehot(freq_onehot), .cpu_khz(cpu_khz),
        .pci_khz(pci_khz), .cpu_swing_25v(cpu_swing_25v), .mode_sel(mode_sel),
        .pwr_down_req(pwr_down_req), .cpu_stop_req(cpu_stop_req));

    // {pins[4:0] = {role, swing, code}, cpu kHz, pci kHz}
    localparam logic [38:0] VEC [8] = '{
        {5'b00000, 17'd50000, 17'd25000},
        {5'b10001, 17'd75000, 17'd32000},
        {5'b01010, 17'd83300, 17'd41650},
        {5'b11011, 17'd68500, 17'd34250},
        {5'b00100, 17'd55000, 17'd27500},
        {5'b11101, 17'd75000, 17'd37500},
        {5'b01110, 17'd60000, 17'd30000},
        {5'b10111, 17'd66800, 17'd33400}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // drop supply at a negedge, load pins, hold two edges, then release
    task automatic power_cycle(input logic [4:0] pins);
        @(negedge clk);
        supply_good   = 1'b0;
        strap_pin_in  = pins;
        shared_pin_in = 2'b00;
        repeat (2) @(negedge clk);
        supply_good = 1'b1;
    endtask

    // after release: count WIN edges with drivers off, then one more
    task automatic run_window(input string tag);
        int early = 0;
        for (int k = 0; k < WIN; k++) begin
            @(negedge clk);
            if (strap_pad_oe != 0 || shared_pad_oe != 0 || config_valid ||
                pwr_down_req || cpu_stop_req) early++;
        end
        chk({tag, " R2 drivers off and requests low through window"}, early, 0);
        @(negedge clk);
        chk({tag, " R3 valid on edge WIN+1"}, config_valid, 1);
        chk({tag, " R3 strap pads enabled"}, strap_pad_oe, 5'b11111);
    endtask

    initial begin
        // R1: powered-off state
        repeat (3) @(negedge clk);
        chk("R1 valid low", config_valid, 0);
        chk("R1 pads off", {strap_pad_oe, shared_pad_oe}, 0);
        chk("R1 fields clear", {freq_code, cpu_swing_25v, mode_sel, pwr_down_req, cpu_stop_req}, 0);
        chk("R1 onehot code 0", freq_onehot, 8'h01);

        for (int v = 0; v < 8; v++) begin
            logic [4:0]  p;
            logic [16:0] ck, pk;
            {p, ck, pk} = VEC[v];
            power_cycle(p);
            run_window($sformatf("vec%0d", v));
            chk("R4 code", freq_code, p[2:0]);
            chk("R4 swing", cpu_swing_25v, p[3]);
            chk("R4 role", mode_sel, p[4]);
            chk("R5 cpu kHz", cpu_khz, ck);
            chk("R5 pci kHz", pci_khz, pk);
            chk("R6 onehot", freq_onehot, 8'h01 << p[2:0]);
            if (p[4]) begin
                // shared pins held low since power-up
                repeat (3) @(negedge clk);
                chk("R8 shared pads driven", shared_pad_oe, 2'b11);
                chk("R8 requests ignored", {pwr_down_req, cpu_stop_req}, 0);
            end else begin
                chk("R9 shared pads hi-z", shared_pad_oe, 2'b00);
                chk("R9 requests from low pins", {pwr_down_req, cpu_stop_req}, 2'b11);
                shared_pin_in = 2'b10;
                @(negedge clk);
                chk("R9 one edge: not yet", {pwr_down_req, cpu_stop_req}, 2'b11);
                @(negedge clk);
                chk("R9 two edges: cpu stop released", {pwr_down_req, cpu_stop_req}, 2'b10);
            end
            // R7: pins now toggling as clocks; capture must hold
            strap_pin_in = ~p;
            repeat (5) @(negedge clk);
            chk("R7 capture ignores pins",
                {freq_code, cpu_swing_25v, mode_sel, config_valid}, {p[2:0], p[3], p[4], 1'b1});
        end

        // R1/R7: supply loss clears at once
        @(negedge clk);
        supply_good = 1'b0;
        #1;
        chk("R7 supply loss clears", {config_valid, freq_code, mode_sel, cpu_swing_25v}, 0);
        chk("R1 pads off after loss", {strap_pad_oe, shared_pad_oe}, 0);

        // R2: brownout mid-window restarts the full window
        power_cycle(5'b00011);
        repeat (WIN / 2) @(negedge clk);
        supply_good = 1'b0;
        @(negedge clk);
        supply_good = 1'b1;
        run_window("restart");
        chk("R2 restart capture", freq_code, 3'd3);

        finished = 1;
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            finish_run();
        end
    end
endmodule